// File: doc/BRIEF.md
# Sub-Second Time Shift Controller

This block keeps a real-time timebase made of a down-counting sub-second prescaler and a binary seconds counter. Both advance only on cycles where the prescaler enable tick is high. Software can move the time through a single register write. The fraction in that write is added into the down-counting prescaler, which holds the clock back by that many prescaler steps. An optional whole-second bit adds one to the seconds count in the same update. Used together, the two give a net advance of one second less the fraction.

A write is accepted only while no earlier shift is waiting. An accepted write raises a busy flag and is applied on the next enable tick. Shadow copies of the sub-second and seconds values are refreshed on the cycle after every tick. A synchronized flag reports whether those copies reflect the time after the latest shift.

Top module: `rtc_shift_ctl`

## Requirements
- R1: After reset, the sub-second count, the seconds count, both shadow values, the busy flag and the synchronized flag are all zero.
- R2: A write presented while the busy flag is high is discarded. Neither its fraction nor its whole-second bit affects the time.
- R3: Without a tick, the live counts hold. On a tick, a non-zero sub-second count decrements by one. A zero count instead reloads from `reload_val` and the seconds count increments by one.
- R4: A write with busy low is accepted. The fraction is taken from `wr_data[14:0]`, the whole-second bit from `wr_data[31]`, and bits 30:15 are ignored. Busy is high from the next cycle. The shift is applied on the first tick after the write cycle, and busy drops with that tick.
- R5: On the tick that applies a shift, the sub-second count becomes the normally stepped value plus the fraction, modulo 2^16. The seconds count becomes the normally stepped value plus the whole-second bit. This also holds when that tick is a second rollover.
- R6: An accepted write clears the synchronized flag on the next cycle.
- R7: On the cycle after each tick, both shadow values take the live counts produced by that tick.
- R8: The synchronized flag is set when the shadows are refreshed, provided no shift is pending. It is never high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shift register write strobe |
| wr_data | input | 32 | Shift write data: fraction in bits 14:0, whole-second bit in bit 31 |
| tick | input | 1 | Prescaler enable tick |
| reload_val | input | 15 | Prescaler reload value |
| ss_live | output | 16 | Live sub-second count |
| sec_live | output | 32 | Live seconds count |
| shift_busy | output | 1 | A shift is pending |
| sync_ok | output | 1 | Shadows hold the time after the latest shift |
| ss_shadow | output | 16 | Shadow sub-second count |
| sec_shadow | output | 32 | Shadow seconds count |

## Verification
Two pairs of events can land together. A pending shift can be applied on the same tick as a second rollover. An accepted write can fall in the same cycle as a tick, in which case the shift must wait for a later tick. The bench steers the prescaler to zero before it applies a shift carrying the whole-second bit. It also issues writes in tick cycles, both directed and through random stimulus. It judges every cycle's counts, flags and shadows against a bench model that first steps the counters and then adds the shift.

// File: rtl/rtc_shift_pkg.sv
package rtc_shift_pkg;
  localparam int REG_W   = 32;
  localparam int FRAC_W  = 15;
  localparam int ADD_BIT = 31;

  typedef struct packed {
    logic              add1;
    logic [FRAC_W-1:0] frac;
  } shift_req_t;
endpackage

// File: rtl/rtc_shift_req.sv
module rtc_shift_req
  import rtc_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             tick,
  output logic             pend,
  output logic             accept,
  output logic             apply,
  output shift_req_t       req
);
  logic       pend_q, pend_n;
  shift_req_t req_q, req_n;
  logic       unused_bits;

  assign unused_bits = ^wr_data[ADD_BIT-1:FRAC_W];
  assign accept = wr_en & ~pend_q;
  assign apply  = pend_q & tick;

  always_comb begin
    pend_n = pend_q;
    req_n  = req_q;
    if (accept) begin
      pend_n     = 1'b1;
      req_n.add1 = wr_data[ADD_BIT];
      req_n.frac = wr_data[FRAC_W-1:0];
    end else if (tick) begin
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= '0;
    end else begin
      pend_q <= pend_n;
      if (accept) req_q <= req_n;
    end
  end

  assign pend = pend_q;
  assign req  = req_q;
endmodule

// File: rtl/rtc_presc.sv
module rtc_presc
  import rtc_shift_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FRAC_W-1:0] reload_val,
  input  logic              apply,
  input  shift_req_t        req,
  output logic [CNT_W-1:0]  cnt,
  output logic [SEC_W-1:0]  sec
);
  localparam int PAD_W = CNT_W - FRAC_W;

  logic [CNT_W-1:0] cnt_q, cnt_n, reload_ext, frac_ext;
  logic [SEC_W-1:0] sec_q, sec_n;

  assign reload_ext = {{PAD_W{1'b0}}, reload_val};
  assign frac_ext   = {{PAD_W{1'b0}}, req.frac};

  always_comb begin
    cnt_n = cnt_q;
    sec_n = sec_q;
    if (cnt_q == '0) begin
      cnt_n = reload_ext;
      sec_n = sec_q + SEC_W'(1);
    end else begin
      cnt_n = cnt_q - CNT_W'(1);
    end
    if (apply) begin
      cnt_n = cnt_n + frac_ext;
      sec_n = sec_n + SEC_W'(req.add1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sec_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_n;
      sec_q <= sec_n;
    end
  end

  assign cnt = cnt_q;
  assign sec = sec_q;
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int CNT_W = 16,
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pend,
  input  logic             accept,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEC_W-1:0] sec,
  output logic [CNT_W-1:0] cnt_sh,
  output logic [SEC_W-1:0] sec_sh,
  output logic             sync
);
  logic             tick_d_q;
  logic             sync_q, sync_n;
  logic [CNT_W-1:0] cnt_sh_q;
  logic [SEC_W-1:0] sec_sh_q;

  always_comb begin
    sync_n = sync_q;
    if (accept)        sync_n = 1'b0;
    else if (tick_d_q) sync_n = ~pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_d_q <= 1'b0;
      sync_q   <= 1'b0;
      cnt_sh_q <= '0;
      sec_sh_q <= '0;
    end else begin
      tick_d_q <= tick;
      sync_q   <= sync_n;
      if (tick_d_q) begin
        cnt_sh_q <= cnt;
        sec_sh_q <= sec;
      end
    end
  end

  assign cnt_sh = cnt_sh_q;
  assign sec_sh = sec_sh_q;
  assign sync   = sync_q;
endmodule

// File: rtl/rtc_shift_ctl.sv
module rtc_shift_ctl
  import rtc_shift_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              tick,
  input  logic [FRAC_W-1:0] reload_val,
  output logic [CNT_W-1:0]  ss_live,
  output logic [SEC_W-1:0]  sec_live,
  output logic              shift_busy,
  output logic              sync_ok,
  output logic [CNT_W-1:0]  ss_shadow,
  output logic [SEC_W-1:0]  sec_shadow
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       pend, accept, apply;
  shift_req_t held_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rtc_shift_req u_req (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .pend(pend), .accept(accept), .apply(apply), .req(held_req)
  );

  rtc_presc #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_presc (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .reload_val(reload_val),
    .apply(apply), .req(held_req), .cnt(ss_live), .sec(sec_live)
  );

  rtc_shadow #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_shadow (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .pend(pend), .accept(accept),
    .cnt(ss_live), .sec(sec_live), .cnt_sh(ss_shadow), .sec_sh(sec_shadow),
    .sync(sync_ok)
  );

  assign shift_busy = pend;
endmodule

// File: rtl/rtc_shift_ctl_chk.sv
module rtc_shift_ctl_chk
  import rtc_shift_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst_n_int,
  input logic             wr_en,
  input logic             tick,
  input logic [CNT_W-1:0] ss_live,
  input logic [SEC_W-1:0] sec_live,
  input logic             shift_busy,
  input logic             sync_ok,
  input logic [CNT_W-1:0] ss_shadow,
  input logic [SEC_W-1:0] sec_shadow,
  input shift_req_t       held_req
);
  a_r2_busy_holds_req: assert property (@(posedge clk) disable iff (!rst_n_int)
    shift_busy |=> $stable(held_req));

  a_r3_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n_int)
    !tick |=> ($stable(ss_live) && $stable(sec_live)));

  a_r4_busy_clears: assert property (@(posedge clk) disable iff (!rst_n_int)
    (shift_busy && tick) |=> !shift_busy);

  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && !shift_busy) |=> shift_busy);

  a_r6_sync_drop: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && !shift_busy) |=> !sync_ok);

  a_r7_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n_int)
    tick ##1 1'b1 |=> ((ss_shadow == $past(ss_live)) && (sec_shadow == $past(sec_live))));

  a_r8_no_sync_busy: assert property (@(posedge clk) disable iff (!rst_n_int)
    shift_busy |-> !sync_ok);
endmodule

bind rtc_shift_ctl rtc_shift_ctl_chk #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n_int(rst_n_int), .wr_en(wr_en), .tick(tick),
  .ss_live(ss_live), .sec_live(sec_live), .shift_busy(shift_busy),
  .sync_ok(sync_ok), .ss_shadow(ss_shadow), .sec_shadow(sec_shadow),
  .held_req(held_req)
);

// File: tb/tb_rtc_shift_ctl.sv
module tb_rtc_shift_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        tick;
  logic [14:0] reload_val;
  logic [15:0] ss_live, ss_shadow;
  logic [31:0] sec_live, sec_shadow;
  logic        shift_busy, sync_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_cnt, m_ssh;
  logic [31:0] m_sec, m_sech;
  logic        m_pend, m_add1, m_tick_d, m_sync;
  logic [14:0] m_frac;

  always #5 clk = ~clk;

  rtc_shift_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .reload_val(reload_val), .ss_live(ss_live), .sec_live(sec_live),
    .shift_busy(shift_busy), .sync_ok(sync_ok), .ss_shadow(ss_shadow),
    .sec_shadow(sec_shadow)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_sec = '0; m_ssh = '0; m_sech = '0;
    m_pend = 0; m_add1 = 0; m_tick_d = 0; m_sync = 0; m_frac = '0;
  endtask

  task automatic model_step(input logic we, input logic [31:0] wd, input logic tk,
                            input logic [14:0] rl);
    logic acc;
    logic [15:0] c;
    logic [31:0] s;
    acc = we && !m_pend;
    c = m_cnt; s = m_sec;
    if (tk) begin
      if (m_cnt == 16'd0) begin c = {1'b0, rl}; s = m_sec + 1; end
      else c = m_cnt - 16'd1;
      if (m_pend) begin c = c + {1'b0, m_frac}; s = s + {31'd0, m_add1}; end
    end
    if (m_tick_d) begin m_ssh = m_cnt; m_sech = m_sec; end
    if (acc) m_sync = 0;
    else if (m_tick_d) m_sync = !m_pend;
    m_tick_d = tk;
    if (acc) begin m_pend = 1; m_frac = wd[14:0]; m_add1 = wd[31]; end
    else if (tk) m_pend = 0;
    m_cnt = c; m_sec = s;
  endtask

  task automatic compare_all();
    chk("R3/R5 sub-second count", 64'(ss_live), 64'(m_cnt));
    chk("R3/R5 seconds count", 64'(sec_live), 64'(m_sec));
    chk("R4 busy flag", 64'(shift_busy), 64'(m_pend));
    chk("R6/R8 sync flag", 64'(sync_ok), 64'(m_sync));
    chk("R7 shadow sub-second", 64'(ss_shadow), 64'(m_ssh));
    chk("R7 shadow seconds", 64'(sec_shadow), 64'(m_sech));
  endtask

  // called at a negedge: drive, step model, wait next negedge, compare
  task automatic cyc(input logic we, input logic [31:0] wd, input logic tk);
    wr_en = we; wr_data = wd; tick = tk;
    model_step(we, wd, tk, reload_val);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s0;
    logic [15:0] c0;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; wr_en = 0; wr_data = '0; tick = 0; reload_val = 15'd4;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sub-second reset", 64'(ss_live), 64'd0);
    chk("R1 seconds reset", 64'(sec_live), 64'd0);
    chk("R1 busy reset", 64'(shift_busy), 64'd0);
    chk("R1 sync reset", 64'(sync_ok), 64'd0);
    chk("R1 shadow reset", 64'({ss_shadow, sec_shadow}), 64'd0);

    // R3 plain counting, reload 4
    for (int i = 0; i < 12; i++) cyc(0, '0, 1);
    cyc(0, '0, 0);
    chk("R3 seconds after 12 ticks", 64'(sec_live), 64'd3);

    // R2 second write while busy is discarded
    cyc(1, 32'h0000_0003, 0);
    s0 = sec_live; c0 = ss_live;
    cyc(1, 32'h8000_0007, 0);
    chk("R2 busy still set", 64'(shift_busy), 64'd1);
    cyc(0, '0, 1);
    chk("R2 no whole second from discarded write", 64'(sec_live),
        64'(c0 == 0 ? s0 + 1 : s0));
    cyc(0, '0, 0);

    // R5 shift tick coinciding with rollover, with whole-second bit
    while (m_cnt != 16'd0) cyc(0, '0, 1);
    s0 = sec_live;
    cyc(1, 32'h8000_0002, 0);
    cyc(0, '0, 1);
    chk("R5 rollover plus whole second", 64'(sec_live), 64'(s0 + 2));
    chk("R5 rollover plus fraction", 64'(ss_live), 64'd6);

    // R4 write in a tick cycle waits for a later tick; upper bits ignored
    c0 = ss_live;
    cyc(1, 32'h7FFF_8001, 1);
    chk("R4 busy after write in tick cycle", 64'(shift_busy), 64'd1);
    chk("R4 tick in write cycle is plain step", 64'(ss_live), 64'(c0 - 1));
    cyc(0, '0, 0);
    cyc(0, '0, 1);
    chk("R4 applied with fraction 1", 64'(ss_live), 64'(c0 - 1));
    chk("R4 busy dropped", 64'(shift_busy), 64'd0);

    // R5 large fraction with large reload, 16-bit wrap
    reload_val = 15'h7FFF;
    while (m_cnt != 16'd0) cyc(0, '0, 1);
    cyc(1, 32'h0000_7FFF, 0);
    cyc(0, '0, 1);
    chk("R5 sum beyond reload", 64'(ss_live), 64'hFFFE);
    cyc(1, 32'h0000_7FFF, 0);
    cyc(0, '0, 1);
    chk("R5 modulo wrap", 64'(ss_live), 64'h7FFC);
    cyc(0, '0, 0);
    cyc(0, '0, 0);
    chk("R8 sync after refresh", 64'(sync_ok), 64'd1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) reload_val = 15'($urandom_range(0, 20));
      cyc(($urandom_range(0, 5) == 0), $urandom(), ($urandom_range(0, 1) == 1));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule